// File: doc/BRIEF.md
# Two-Function Card Status Change Registers

This block keeps the per-function control and status bytes of a two-function card interface controller. For each function it holds a configuration status byte and a pin replacement byte. The configuration status byte gates a shared status-change line, powers the function down and enables the speaker path. The pin replacement byte brings out the function's ready/busy input and a sticky flag that records every ready/busy transition.

The host reaches the four bytes through a byte-wide port with one address. Address bit 0 selects the byte kind and the upper bit selects the function. Writes take effect on the clock edge. Reads are combinational from the current address.

The block drives three outputs from the stored state. The first is the active-low status-change line, which only asserts in I/O interface mode. The second is one active-high power-control line per function. The third is an active-low speaker output that follows the speaker input while enabled.

Top module: `card_status_regs`

## Requirements
- R1: Reset is synchronous and active-low. While it is low, every stored bit and every change flag is zero, the ready sample follows `readyIn`, and no change flag can set. This gives pwrCtl = all ones, statChgN = 1 and spkOutN = 1.
- R2: hostAddr[0] selects the byte: 0 is the configuration status byte and 1 is the pin replacement byte. hostAddr[1] selects function 0 or 1. hostRdData is combinational from hostAddr and the current state.
- R3: In the configuration status byte, the host-writable storage bits are bit 6 (SigChg), bit 5 (IOis8), bit 3 (Audio), bit 2 (PwrDn) and bit 0 (IntrReset). A write stores these bits on the write edge. Bits 4 and 1 always read 0, and writes to bits 7, 4 and 1 are ignored.
- R4: The pin replacement byte reads bit 1 as the function's ready input as sampled at the last clock edge, and bit 5 as the change flag. Every other bit reads 0.
- R5: A function's change flag sets on the edge where its ready input differs from the previous sample. It then stays set until it is cleared.
- R6: A write to a pin replacement byte with bit 5 = 1 clears that function's change flag, and a write with bit 5 = 0 leaves it unchanged. If a ready transition occurs on the same edge as the clear, the flag stays set.
- R7: Bit 7 (Changed) of the configuration status byte is read-only and equals that function's change flag.
- R8: statChgN is 0 exactly when ioMode = 1 and at least one function has both its change flag and SigChg set. statChgN responds combinationally to ioMode.
- R9: pwrCtl[f] is the inverse of PwrDn of function f.
- R10: spkOutN = ~spkIn when some function has Audio = 1 and fnConfigured = 1; otherwise spkOutN = 1.
- R11: A write addressed to one function never changes any byte of the other function.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| hostAddr | input | 2 | Byte select: bit 1 function, bit 0 kind |
| hostWrEn | input | 1 | Host write strobe, one byte per cycle |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 8 | Read data for hostAddr |
| readyIn | input | 2 | Ready/busy input per function |
| ioMode | input | 1 | Card operates as an I/O interface |
| fnConfigured | input | 2 | Function configured, per function |
| spkIn | input | 1 | Speaker source signal |
| statChgN | output | 1 | Active-low shared status-change line |
| pwrCtl | output | 2 | Active-high power control per function |
| spkOutN | output | 1 | Active-low speaker output |

## Verification
A stored bit that is lost or corrupted shows up as a wrong byte at the next read of its address. When that bit is PwrDn, Audio or SigChg, it also shows on pwrCtl, spkOutN or statChgN in the same cycle. A change flag that misses a transition, or that clears when it should not, alters the Changed bit and the status-change line one edge after the event. For this reason the bench checks those outputs every cycle, including the edge where a transition coincides with a clearing write.

// File: rtl/csr_pkg.sv
`timescale 1ns/1ps
package csr_pkg;
  parameter int FN_COUNT = 2;
  parameter int DATA_W = 8;
  localparam int FN_W = (FN_COUNT > 1) ? $clog2(FN_COUNT) : 1;
  localparam int ADDR_W = FN_W + 1;

  // configuration status byte fields
  localparam int CFG_CHANGED = 7;
  localparam int CFG_SIGCHG = 6;
  localparam int CFG_IO8 = 5;
  localparam int CFG_AUDIO = 3;
  localparam int CFG_PWRDN = 2;
  localparam int CFG_INTRST = 0;
  // pin replacement byte fields
  localparam int PIN_CRDY = 5;
  localparam int PIN_RRDY = 1;

  localparam logic [DATA_W-1:0] CFG_WR_MASK =
    DATA_W'((1 << CFG_SIGCHG) | (1 << CFG_IO8) | (1 << CFG_AUDIO) |
            (1 << CFG_PWRDN) | (1 << CFG_INTRST));

  typedef struct packed {
    logic [FN_COUNT-1:0] cfgWr;
    logic [FN_COUNT-1:0] pinWr;
    logic [DATA_W-1:0]   wrData;
    logic [FN_W-1:0]     rdFn;
    logic                rdPin;
    logic                rdValid;
  } hostStrobe_t;
endpackage

// File: rtl/csr_host_ctrl.sv
`timescale 1ns/1ps
module csr_host_ctrl
  import csr_pkg::*;
(
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  output hostStrobe_t       strb
);
  logic [FN_W-1:0] fnSel;
  logic            fnInRange;

  assign fnSel     = hostAddr[ADDR_W-1:1];
  assign fnInRange = (32'(fnSel) < FN_COUNT);

  for (genvar f = 0; f < FN_COUNT; f++) begin : g_dec
    assign strb.cfgWr[f] = hostWrEn && !hostAddr[0] && (fnSel == FN_W'(f));
    assign strb.pinWr[f] = hostWrEn &&  hostAddr[0] && (fnSel == FN_W'(f));
  end

  assign strb.wrData  = hostWrData;
  assign strb.rdFn    = fnSel;
  assign strb.rdPin   = hostAddr[0];
  assign strb.rdValid = fnInRange;
endmodule

// File: rtl/csr_regs_dp.sv
`timescale 1ns/1ps
module csr_regs_dp
  import csr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  hostStrobe_t         strb,
  input  logic [FN_COUNT-1:0] readyIn,
  input  logic                ioMode,
  input  logic [FN_COUNT-1:0] fnConfigured,
  input  logic                spkIn,
  output logic [DATA_W-1:0]   rdData,
  output logic                statChgN,
  output logic [FN_COUNT-1:0] pwrCtl,
  output logic                spkOutN
);
  logic [DATA_W-1:0]   cfgStore [FN_COUNT];
  logic [DATA_W-1:0]   cfgByte  [FN_COUNT];
  logic [DATA_W-1:0]   pinByte  [FN_COUNT];
  logic [FN_COUNT-1:0] readyQ;
  logic [FN_COUNT-1:0] cRdy;
  logic [FN_COUNT-1:0] sigChg;
  logic [FN_COUNT-1:0] audio;
  logic [FN_COUNT-1:0] pwrDn;
  logic [FN_COUNT-1:0] chgGate;

  for (genvar f = 0; f < FN_COUNT; f++) begin : g_fn
    logic rdyEdge;
    logic clrReq;
    assign rdyEdge = readyIn[f] ^ readyQ[f];
    assign clrReq  = strb.pinWr[f] && strb.wrData[PIN_CRDY];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgStore[f] <= '0;
        cRdy[f]     <= 1'b0;
        readyQ[f]   <= readyIn[f];
      end else begin
        readyQ[f] <= readyIn[f];
        if (strb.cfgWr[f]) cfgStore[f] <= strb.wrData & CFG_WR_MASK;
        if (rdyEdge)       cRdy[f] <= 1'b1;
        else if (clrReq)   cRdy[f] <= 1'b0;
      end
    end

    always_comb begin
      cfgByte[f] = cfgStore[f];
      cfgByte[f][CFG_CHANGED] = cRdy[f];
      pinByte[f] = '0;
      pinByte[f][PIN_CRDY] = cRdy[f];
      pinByte[f][PIN_RRDY] = readyQ[f];
    end

    assign sigChg[f]  = cfgStore[f][CFG_SIGCHG];
    assign audio[f]   = cfgStore[f][CFG_AUDIO];
    assign pwrDn[f]   = cfgStore[f][CFG_PWRDN];
    assign chgGate[f] = cRdy[f] && sigChg[f];

    // R5
    chg_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      (readyIn[f] != readyQ[f]) |=> cRdy[f]);
    // R6
    chg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cRdy[f] && !(strb.pinWr[f] && strb.wrData[PIN_CRDY])) |=> cRdy[f]);
    // R6
    chg_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.pinWr[f] && strb.wrData[PIN_CRDY] && (readyIn[f] == readyQ[f]))
      |=> !cRdy[f]);
    // R9
    pwr_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.cfgWr[f] |=> (pwrCtl[f] == !$past(strb.wrData[CFG_PWRDN])));
    // R11
    cfg_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strb.cfgWr[f] |=> $stable(cfgStore[f]));
  end

  always_comb begin
    if (!strb.rdValid)   rdData = '0;
    else if (strb.rdPin) rdData = pinByte[strb.rdFn];
    else                 rdData = cfgByte[strb.rdFn];
  end

  assign statChgN = !(ioMode && (|chgGate));
  assign pwrCtl   = ~pwrDn;
  assign spkOutN  = !((|(audio & fnConfigured)) && spkIn);
endmodule

// File: rtl/card_status_regs.sv
`timescale 1ns/1ps
module card_status_regs
  import csr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic                hostWrEn,
  input  logic [DATA_W-1:0]   hostWrData,
  output logic [DATA_W-1:0]   hostRdData,
  input  logic [FN_COUNT-1:0] readyIn,
  input  logic                ioMode,
  input  logic [FN_COUNT-1:0] fnConfigured,
  input  logic                spkIn,
  output logic                statChgN,
  output logic [FN_COUNT-1:0] pwrCtl,
  output logic                spkOutN
);
  hostStrobe_t strb;

  csr_host_ctrl ctrl_i (
    .hostAddr   (hostAddr),
    .hostWrEn   (hostWrEn),
    .hostWrData (hostWrData),
    .strb       (strb)
  );

  csr_regs_dp dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .readyIn      (readyIn),
    .ioMode       (ioMode),
    .fnConfigured (fnConfigured),
    .spkIn        (spkIn),
    .rdData       (hostRdData),
    .statChgN     (statChgN),
    .pwrCtl       (pwrCtl),
    .spkOutN      (spkOutN)
  );
endmodule

// File: tb/card_status_regs_tb.sv
`timescale 1ns/1ps
module card_status_regs_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] hostAddr;
  logic       hostWrEn;
  logic [7:0] hostWrData;
  logic [7:0] hostRdData;
  logic [1:0] readyIn;
  logic       ioMode;
  logic [1:0] fnConfigured;
  logic       spkIn;
  logic       statChgN;
  logic [1:0] pwrCtl;
  logic       spkOutN;

  int  total = 0;
  int  bad = 0;
  bit  done = 0;

  logic [7:0] mCfg [2];
  logic       mCrdy [2];
  logic       mRrdy [2];
  bit         mValid = 0;

  always #2.5 clk = ~clk;

  card_status_regs dut_i (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .readyIn(readyIn),
    .ioMode(ioMode), .fnConfigured(fnConfigured), .spkIn(spkIn),
    .statChgN(statChgN), .pwrCtl(pwrCtl), .spkOutN(spkOutN)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model, updated at each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      for (int f = 0; f < 2; f++) begin
        mCfg[f] = 8'h00; mCrdy[f] = 1'b0; mRrdy[f] = readyIn[f];
      end
      mValid = 1;
    end else begin
      for (int f = 0; f < 2; f++) begin
        if (hostWrEn && hostAddr[1] == f[0] && !hostAddr[0])
          mCfg[f] = hostWrData & 8'h6D;
        if (readyIn[f] != mRrdy[f]) mCrdy[f] = 1'b1;
        else if (hostWrEn && hostAddr[1] == f[0] && hostAddr[0] && hostWrData[5])
          mCrdy[f] = 1'b0;
        mRrdy[f] = readyIn[f];
      end
    end
  end

  function automatic logic [7:0] expRead(input logic [1:0] a);
    int f = int'(a[1]);
    if (a[0]) return {2'b00, mCrdy[f], 3'b000, mRrdy[f], 1'b0};
    return mCfg[f] | {mCrdy[f], 7'b0};
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (mValid && !done) begin
      chk(hostAddr[0] ? "R4 pin byte" : "R3 cfg byte", hostRdData, expRead(hostAddr));
      chk("R8 status change", {7'b0, statChgN},
          {7'b0, !(ioMode && ((mCrdy[0] && mCfg[0][6]) || (mCrdy[1] && mCfg[1][6])))});
      chk("R9 power control", {6'b0, pwrCtl}, {6'b0, !mCfg[1][2], !mCfg[0][2]});
      chk("R10 speaker", {7'b0, spkOutN},
          {7'b0, !(((mCfg[0][3] && fnConfigured[0]) || (mCfg[1][3] && fnConfigured[1])) && spkIn)});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(posedge clk); #2;
    hostWrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [1:0] a, input logic [7:0] e, input string tag);
    hostAddr = a;
    #1;
    chk(tag, hostRdData, e);
  endtask

  initial begin
    rstN = 0; hostAddr = 0; hostWrEn = 0; hostWrData = 0;
    readyIn = 2'b01; ioMode = 0; fnConfigured = 0; spkIn = 0;
    tick(2);
    rdChk(2'd1, 8'h02, "R1 ready sample in reset");
    readyIn = 2'b00;
    tick(1);
    rdChk(2'd1, 8'h00, "R1 no change flag in reset");
    rstN = 1;
    tick(1);
    rdChk(2'd0, 8'h00, "R1 cfg0 reset");
    chk("R1 pwrCtl reset", {6'b0, pwrCtl}, 8'h03);
    chk("R1 statChgN reset", {7'b0, statChgN}, 8'h01);
    chk("R1 spkOutN reset", {7'b0, spkOutN}, 8'h01);

    wr(2'd0, 8'hFF);
    rdChk(2'd0, 8'h6D, "R3 writable bits");
    rdChk(2'd2, 8'h00, "R11 other function untouched");
    chk("R9 pwrdn set", {6'b0, pwrCtl}, 8'h02);

    readyIn[1] = 1'b1;
    tick(1);
    rdChk(2'd3, 8'h22, "R5 change flag set");
    rdChk(2'd2, 8'h80, "R7 changed bit");
    rdChk(2'd1, 8'h00, "R2 pin0 distinct from pin1");

    ioMode = 0; #1;
    chk("R8 outside io mode", {7'b0, statChgN}, 8'h01);
    ioMode = 1; #1;
    chk("R8 sigchg clear gates", {7'b0, statChgN}, 8'h01);
    wr(2'd2, 8'h40);
    #1;
    chk("R8 asserted", {7'b0, statChgN}, 8'h00);
    ioMode = 0; #1;
    chk("R8 io mode off", {7'b0, statChgN}, 8'h01);
    ioMode = 1;

    wr(2'd3, 8'h00);
    rdChk(2'd3, 8'h22, "R6 write zero keeps flag");
    wr(2'd3, 8'hDF);
    rdChk(2'd3, 8'h22, "R6 other bits keep flag");
    wr(2'd3, 8'h20);
    rdChk(2'd3, 8'h02, "R6 write one clears");
    chk("R8 deasserted after clear", {7'b0, statChgN}, 8'h01);

    readyIn[0] = 1'b1;
    tick(1);
    rdChk(2'd1, 8'h22, "R5 flag on function 0");
    hostAddr = 2'd1; hostWrData = 8'h20; hostWrEn = 1'b1; readyIn[0] = 1'b0;
    @(posedge clk); #2;
    hostWrEn = 1'b0;
    rdChk(2'd1, 8'h20, "R6 set wins over clear");
    wr(2'd1, 8'h20);
    rdChk(2'd1, 8'h00, "R6 clear after collision");

    fnConfigured = 2'b00; spkIn = 1; #1;
    chk("R10 unconfigured", {7'b0, spkOutN}, 8'h01);
    fnConfigured = 2'b01; #1;
    chk("R10 enabled high", {7'b0, spkOutN}, 8'h00);
    spkIn = 0; #1;
    chk("R10 enabled low", {7'b0, spkOutN}, 8'h01);
    fnConfigured = 2'b10; spkIn = 1; #1;
    chk("R10 audio off on fn1", {7'b0, spkOutN}, 8'h01);
    wr(2'd2, 8'h08);
    #1;
    chk("R10 audio on fn1", {7'b0, spkOutN}, 8'h00);

    wr(2'd0, 8'h00);
    chk("R9 pwrdn cleared", {6'b0, pwrCtl}, 8'h03);
    rdChk(2'd0, 8'h00, "R3 cleared");
    rdChk(2'd2, 8'h08, "R11 fn1 kept");

    for (int i = 0; i < 600; i++) begin
      hostWrEn = ($urandom_range(0, 2) == 0);
      hostAddr = 2'($urandom_range(0, 3));
      hostWrData = 8'($urandom);
      if ($urandom_range(0, 3) == 0) readyIn = 2'($urandom);
      if ($urandom_range(0, 7) == 0) ioMode = ~ioMode;
      if ($urandom_range(0, 7) == 0) fnConfigured = 2'($urandom);
      spkIn = 1'($urandom);
      tick(1);
    end
    hostWrEn = 0;
    tick(2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule